// File: doc/BRIEF.md
# Tooth-Wheel Angle Counter

This block turns a toothed-wheel sensor signal into a 24-bit angle count that other timer channels can use as a compare or capture base. It times each tooth interval in system clocks. Over the following interval it issues a selectable number of evenly spaced angle ticks, sized from the interval it has just measured. The spacing comes from a fractional accumulator, so no divider is needed and no rounding error builds up inside an interval.

The angle count only moves forward. A tooth that comes early makes the count jump to that tooth's boundary. If a tooth comes late, counting stops at the boundary and waits for the edge. A wheel can have one missing tooth at the last position of the revolution. The interval over that gap then carries twice the ticks of a normal interval. The block recognises the gap from its length, which realigns the count to the start of the revolution. The count returns to zero once per revolution, and a flag pulses at that moment.

The control path is a four-state machine:
- ST_IDLE: no edge has been seen yet.
- ST_MEAS: one edge has been seen and the first interval is being timed.
- ST_RUN: ticks are being issued.
- ST_HOLD: all ticks of the current interval have been issued, and the block waits for the next edge.

Its transitions are:
- IDLE→MEAS on the first edge.
- MEAS→RUN on the second edge.
- RUN→HOLD when the last tick of the interval is issued.
- RUN→RUN and HOLD→RUN on every tooth edge.

Top module: `tooth_angle_counter`

## Requirements
- R1: After reset the outputs are angle_o = 0, tick_o = 0, rev_o = 0, synced_o = 0 and hold_o = 0.
- R2: Before two rising edges of tooth_i have been seen, synced_o stays 0 and angle_o stays 0. On the clock of the second edge, synced_o becomes 1 and angle_o is 0. The number of clocks between the two edges becomes the reference period.
- R3: Let an interval start at a tooth edge with angle base B, reference period P and ticks-per-tooth T, where 1 ≤ T ≤ P. Sampled k clocks after that edge, angle_o equals B + min(floor(k·T/P), target). Each increase is a single step of 1, and tick_o is 1 in exactly the cycles where angle_o stepped.
- R4: The target of an interval is T, or 2·T for the gap interval. Once the target has been issued and before the next edge arrives, hold_o is 1 and angle_o does not change.
- R5: angle_o never decreases, except in the cycle where rev_o is 1. In that cycle angle_o is 0.
- R6: On a tooth edge that arrives before all ticks have been issued, angle_o jumps in that same clock to B + target. The new interval starts from that value.
- R7: The tooth index starts at 0 on the second edge and advances by one per tooth, or by two across the gap interval. When the index reaches teeth_i, angle_o becomes 0 and rev_o is 1 for exactly one clock.
- R8: tpt_i is read live. A new value applied just after a tooth edge sets both the tick rate and the target of that interval.
- R9: With gap_en_i = 1, the interval that starts at tooth index teeth_i−2 has target 2·T. An edge whose period satisfies period·2 > reference·3 is treated as the gap. That edge sets angle_o to 0, pulses rev_o, and sets the next reference to period/2.
- R10: Apart from the gap case, each tooth edge replaces the reference period with the length of the interval that just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| tooth_i | input | 1 | Tooth sensor level, synchronous to clk; the rising edge is the tooth event |
| tpt_i | input | 8 | Ticks per tooth (1 or more) |
| teeth_i | input | 8 | Tooth positions per revolution, including a missing one |
| gap_en_i | input | 1 | Wheel has a missing tooth at the last position |
| angle_o | output | 24 | Angle count |
| tick_o | output | 1 | Pulses in each cycle where angle_o stepped by one tick |
| rev_o | output | 1 | One-clock pulse at the revolution wrap |
| synced_o | output | 1 | Counting is active (two edges seen) |
| hold_o | output | 1 | All ticks of the current interval issued, waiting for the edge |

## Verification
The bench builds the block with its default widths: 24-bit angle, 16-bit period timer, 8-bit tooth and tick fields. It sets six tooth positions and uses periods of 10 to 40 clocks, so a full revolution and its wrap occur within a few hundred cycles. With 4 and then 8 ticks per tooth, it reaches an on-time tooth, a late tooth that parks the count at the boundary, and an early tooth that forces a jump. A second run with the gap enabled covers the double-length interval, its detection against the 1.5× threshold, and the halved reference that follows it.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } tw_state_e;
endpackage

// File: rtl/tw_edge_timer.sv
`timescale 1ns/1ps
module tw_edge_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tooth_i,
    output logic             edge_o,
    output logic [PER_W-1:0] period_o
);
    logic             tooth_q;
    logic [PER_W-1:0] timer_q;

    assign edge_o   = tooth_i & ~tooth_q;
    assign period_o = timer_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tooth_q <= 1'b0;
            timer_q <= '1;
        end else begin
            tooth_q <= tooth_i;
            if (edge_o)
                timer_q <= PER_W'(1);
            else if (timer_q != '1)
                timer_q <= timer_q + 1'b1;
        end
    end

    // R2: the timer restarts at one clock after every tooth edge
    assert_timer_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (period_o == PER_W'(1)));
endmodule

// File: rtl/tw_tick_gen.sv
`timescale 1ns/1ps
module tw_tick_gen #(
    parameter int PER_W = 16,
    parameter int TPT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [PER_W-1:0] ref_i,
    input  logic [TPT_W-1:0] tpt_i,
    output logic             fire_o
);
    localparam int ACC_W = PER_W + TPT_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_n;

    assign acc_n  = acc_q + ACC_W'(tpt_i);
    assign fire_o = en_i && (acc_n >= ACC_W'(ref_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr_i)
            acc_q <= '0;
        else if (en_i)
            acc_q <= fire_o ? (acc_n - ACC_W'(ref_i)) : acc_n;
    end

    // R3: with tpt no larger than the reference, the remainder stays below the reference
    assert_acc_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && (ACC_W'(tpt_i) <= ACC_W'(ref_i)) && (acc_q < ACC_W'(ref_i)))
        |=> (acc_q < ACC_W'($past(ref_i))));
endmodule

// File: rtl/tw_angle_ctrl.sv
`timescale 1ns/1ps
module tw_angle_ctrl
    import tw_pkg::*;
#(
    parameter int ANG_W = 24,
    parameter int PER_W = 16,
    parameter int TPT_W = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             fire_i,
    input  logic [TPT_W-1:0] tpt_i,
    input  logic [IDX_W-1:0] teeth_i,
    input  logic             gap_en_i,
    output logic             tick_en_o,
    output logic [PER_W-1:0] ref_o,
    output logic [ANG_W-1:0] angle_o,
    output logic             tick_o,
    output logic             rev_o,
    output logic             synced_o,
    output logic             hold_o
);
    localparam int TGT_W = TPT_W + 1;

    tw_state_e        state_q, state_n;
    logic [ANG_W-1:0] angle_q, base_q;
    logic [PER_W-1:0] ref_q;
    logic [IDX_W-1:0] idx_q;
    logic [TGT_W-1:0] cnt_q;
    logic             tick_q, rev_q;

    logic             gap_int;
    logic [TGT_W-1:0] target;
    logic [PER_W+1:0] per_x2, ref_x3;
    logic             is_gap;
    logic [IDX_W:0]   idx_step;
    logic             wrap;
    logic [ANG_W-1:0] boundary, angle_at_edge;
    logic [PER_W-1:0] half_per, ref_next;
    logic             last_tick;

    // interval shape
    assign gap_int  = gap_en_i && (idx_q == (teeth_i - IDX_W'(2)));
    assign target   = gap_int ? {tpt_i, 1'b0} : {1'b0, tpt_i};
    assign per_x2   = {1'b0, period_i, 1'b0};
    assign ref_x3   = {2'b00, ref_q} + {1'b0, ref_q, 1'b0};
    assign is_gap   = gap_en_i && (per_x2 > ref_x3);
    assign idx_step = {1'b0, idx_q} + (gap_int ? (IDX_W+1)'(2) : (IDX_W+1)'(1));
    assign wrap     = is_gap || (idx_step >= {1'b0, teeth_i});
    assign boundary = base_q + ANG_W'(target);
    assign angle_at_edge = wrap ? '0 : ((boundary > angle_q) ? boundary : angle_q);
    assign half_per = {1'b0, period_i[PER_W-1:1]};
    assign ref_next = is_gap ? ((half_per == '0) ? PER_W'(1) : half_per) : period_i;
    assign last_tick = (cnt_q + 1'b1) >= target;

    assign tick_en_o = (state_q == ST_RUN) && !edge_i && (cnt_q < target);
    assign ref_o     = ref_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (edge_i) state_n = ST_MEAS;
            ST_MEAS: if (edge_i) state_n = ST_RUN;
            ST_RUN: begin
                if (edge_i)
                    state_n = ST_RUN;
                else if (fire_i && last_tick)
                    state_n = ST_HOLD;
            end
            ST_HOLD: if (edge_i) state_n = ST_RUN;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            angle_q <= '0;
            base_q  <= '0;
            ref_q   <= PER_W'(1);
            idx_q   <= '0;
            cnt_q   <= '0;
            tick_q  <= 1'b0;
            rev_q   <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            rev_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    angle_q <= '0;
                end
                ST_MEAS: begin
                    if (edge_i) begin
                        ref_q   <= (period_i == '0) ? PER_W'(1) : period_i;
                        angle_q <= '0;
                        base_q  <= '0;
                        idx_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN, ST_HOLD: begin
                    if (edge_i) begin
                        angle_q <= angle_at_edge;
                        base_q  <= angle_at_edge;
                        idx_q   <= wrap ? '0 : idx_step[IDX_W-1:0];
                        ref_q   <= ref_next;
                        cnt_q   <= '0;
                        rev_q   <= wrap;
                    end else if (fire_i) begin
                        angle_q <= angle_q + 1'b1;
                        cnt_q   <= cnt_q + 1'b1;
                        tick_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        angle_o  = angle_q;
        tick_o   = tick_q;
        rev_o    = rev_q;
        synced_o = (state_q == ST_RUN) || (state_q == ST_HOLD);
        hold_o   = (state_q == ST_HOLD);
    end

    // R2: nothing counts before synchronisation
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !synced_o |-> (angle_o == '0) && !tick_o && !rev_o);
    // R3: a tick is a single step
    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (angle_o == $past(angle_o) + 1'b1));
    // R4: parked at the boundary while holding
    assert_hold_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> (angle_o == $past(angle_o)) || rev_o);
    // R5: count only moves forward outside the wrap
    assert_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_o |-> (angle_o >= $past(angle_o)));
    // R7: wrap pulse is one clock and lands on zero
    assert_rev_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rev_o |-> (angle_o == '0) ##1 !rev_o);
endmodule

// File: rtl/tooth_angle_counter.sv
`timescale 1ns/1ps
module tooth_angle_counter #(
    parameter int ANG_W = 24,
    parameter int PER_W = 16,
    parameter int TPT_W = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tooth_i,
    input  logic [TPT_W-1:0] tpt_i,
    input  logic [IDX_W-1:0] teeth_i,
    input  logic             gap_en_i,
    output logic [ANG_W-1:0] angle_o,
    output logic             tick_o,
    output logic             rev_o,
    output logic             synced_o,
    output logic             hold_o
);
    logic             edge_w;
    logic [PER_W-1:0] period_w;
    logic [PER_W-1:0] ref_w;
    logic             tick_en_w;
    logic             fire_w;

    tw_edge_timer #(.PER_W(PER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tooth_i  (tooth_i),
        .edge_o   (edge_w),
        .period_o (period_w)
    );

    tw_tick_gen #(.PER_W(PER_W), .TPT_W(TPT_W)) u_ticks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (edge_w),
        .en_i   (tick_en_w),
        .ref_i  (ref_w),
        .tpt_i  (tpt_i),
        .fire_o (fire_w)
    );

    tw_angle_ctrl #(.ANG_W(ANG_W), .PER_W(PER_W), .TPT_W(TPT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_w),
        .period_i  (period_w),
        .fire_i    (fire_w),
        .tpt_i     (tpt_i),
        .teeth_i   (teeth_i),
        .gap_en_i  (gap_en_i),
        .tick_en_o (tick_en_w),
        .ref_o     (ref_w),
        .angle_o   (angle_o),
        .tick_o    (tick_o),
        .rev_o     (rev_o),
        .synced_o  (synced_o),
        .hold_o    (hold_o)
    );
endmodule

// File: tb/test_tooth_angle_counter.sv
`timescale 1ns/1ps
module test_tooth_angle_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tooth_i = 1'b0;
    logic [7:0]  tpt_i = 8'd4;
    logic [7:0]  teeth_i = 8'd6;
    logic        gap_en_i = 1'b0;
    logic [23:0] angle_o;
    logic        tick_o, rev_o, synced_o, hold_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tooth_angle_counter i_tooth_angle_counter (
        .clk(clk), .rst_n(rst_n), .tooth_i(tooth_i), .tpt_i(tpt_i),
        .teeth_i(teeth_i), .gap_en_i(gap_en_i), .angle_o(angle_o),
        .tick_o(tick_o), .rev_o(rev_o), .synced_o(synced_o), .hold_o(hold_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tooth_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fire_edge();
        tooth_i = 1'b1;
        @(negedge clk);
        tooth_i = 1'b0;
    endtask

    // before synchronisation: quiet, then second edge after p clocks
    task automatic sync_interval(input int p);
        for (int k = 1; k < p; k++) begin
            @(negedge clk);
            chk(synced_o == 1'b0, "R2 synced", int'(synced_o), 0);
            chk(angle_o == 24'd0, "R2 angle", int'(angle_o), 0);
        end
        fire_edge();
        chk(synced_o == 1'b1, "R2 synced after second edge", int'(synced_o), 1);
        chk(angle_o == 24'd0, "R2 angle after second edge", int'(angle_o), 0);
    endtask

    // one tooth interval of p clocks, expecting reference rf and tick count tp
    task automatic tooth_interval(input int p, input int rf, input int tp, input int base,
                                  input int tgt, input int after, input bit exp_rev,
                                  input string req);
        int prev_ticks = 0;
        for (int k = 1; k < p; k++) begin
            int raw = (k * tp) / rf;
            int n = (raw > tgt) ? tgt : raw;
            @(negedge clk);
            chk(angle_o == 24'(base + n), {req, " R3 angle"}, int'(angle_o), base + n);
            chk(tick_o == (n > prev_ticks), {req, " R3 tick"}, int'(tick_o), int'(n > prev_ticks));
            chk(hold_o == (raw >= tgt), {req, " R4 hold"}, int'(hold_o), int'(raw >= tgt));
            chk(rev_o == 1'b0, {req, " R7 rev low"}, int'(rev_o), 0);
            prev_ticks = n;
        end
        fire_edge();
        chk(angle_o == 24'(after), {req, " boundary"}, int'(angle_o), after);
        chk(rev_o == exp_rev, {req, " R7 rev at edge"}, int'(rev_o), int'(exp_rev));
        chk(hold_o == 1'b0, {req, " R4 hold cleared"}, int'(hold_o), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(angle_o == 24'd0, "R1 angle", int'(angle_o), 0);
        chk(tick_o == 1'b0, "R1 tick", int'(tick_o), 0);
        chk(rev_o == 1'b0, "R1 rev", int'(rev_o), 0);
        chk(synced_o == 1'b0, "R1 synced", int'(synced_o), 0);
        chk(hold_o == 1'b0, "R1 hold", int'(hold_o), 0);
    endtask

    task automatic t_plain_wheel();
        gap_en_i = 1'b0; teeth_i = 8'd6; tpt_i = 8'd4;
        fire_edge();
        sync_interval(20);                                     // R2
        tooth_interval(20, 20, 4, 0, 4, 4, 1'b0, "R3 on-time");
        tooth_interval(20, 20, 4, 4, 4, 8, 1'b0, "R10 steady");
        tooth_interval(30, 20, 4, 8, 4, 12, 1'b0, "R4 late");
        tooth_interval(10, 30, 4, 12, 4, 16, 1'b0, "R6 early R10");
        tooth_interval(10, 10, 4, 16, 4, 20, 1'b0, "R5 after jump");
        tooth_interval(10, 10, 4, 20, 4, 0, 1'b1, "R7 wrap");
        tpt_i = 8'd8;
        tooth_interval(10, 10, 8, 0, 8, 8, 1'b0, "R8 tpt change");
    endtask

    task automatic t_gap_wheel();
        gap_en_i = 1'b1; teeth_i = 8'd6; tpt_i = 8'd4;
        do_reset();
        fire_edge();
        sync_interval(20);
        tooth_interval(20, 20, 4, 0, 4, 4, 1'b0, "R9 tooth0");
        tooth_interval(20, 20, 4, 4, 4, 8, 1'b0, "R9 tooth1");
        tooth_interval(20, 20, 4, 8, 4, 12, 1'b0, "R9 tooth2");
        tooth_interval(20, 20, 4, 12, 4, 16, 1'b0, "R9 tooth3");
        tooth_interval(40, 20, 4, 16, 8, 0, 1'b1, "R9 gap");
        tooth_interval(20, 20, 4, 0, 4, 4, 1'b0, "R9 halved ref");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_plain_wheel();
        t_gap_wheel();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule